// File: doc/BRIEF.md
# USB Full-Speed Packet Transmitter

This block turns one packet request into the line-level symbol stream of a full-speed USB 1.1 packet. Each request names a packet kind. Token kinds carry an address and an endpoint. A start-of-frame request carries a frame number. Data kinds carry a byte count, and their bytes arrive on a ready/valid stream.

The block emits SYNC, the PID, the kind's fields, the CRC and the end-of-packet sequence. It applies NRZI coding and bit stuffing as the symbols go out. It drives a two-wire line interface: a data wire and an SE0 flag. When the SE0 flag is high the line is in SE0. Otherwise the data wire reads 1 for J and 0 for K.

The line advances by exactly one symbol on each bit-enable strobe, so a single clock domain can serve any bit rate. Bus turnaround and analog drive belong to the surrounding logic.

Top module: `usb_fs_pkt_tx`

## Requirements
- R1: Out of reset the line shows J (`line_dp_o`=1, `line_se0_o`=0), with `busy_o`=0, `done_o`=0, `req_ready_o`=1 and `byte_ready_o`=0.
- R2: The first eight symbols of every packet are the forced levels K J K J K J K K. After them, the NRZI level is K and the ones count is zero.
- R3: The PID follows SYNC, bit 0 first. The kind codes and their PID bytes are:

  | Code | Kind | PID byte |
  |------|------|----------|
  | 0 | OUT | 8'hE1 |
  | 1 | IN | 8'h69 |
  | 2 | SETUP | 8'h2D |
  | 3 | SOF | 8'hA5 |
  | 4 | DATA0 | 8'hC3 |
  | 5 | DATA1 | 8'h4B |
  | 6 | ACK | 8'hD2 |
  | 7 | NAK | 8'h5A |
  | 8 | STALL | 8'h1E |
- R4: Every data bit is NRZI coded: a 0 toggles the line level and a 1 keeps it.
- R5: After six 1 bits in a row, one extra toggled level is inserted and the ones count clears. Any toggle also clears the count. Stuffing runs through every field, and it also applies after the last CRC bit before EOP. A stuffed level consumes no data bit.
- R6: Token kinds (codes 0 to 2) send the 7-bit address and then the 4-bit endpoint. SOF sends the 11-bit frame number. All of these go bit 0 first. They are followed by the one's complement of the CRC5 register, register MSB first.
- R7: Data kinds send the bytes in stream order, each byte bit 0 first. They are followed by the one's complement of the CRC16 register, MSB first. A zero-length data packet sends only the CRC16.
- R8: The CRC registers are preset to all ones once the PID has been sent. Each field bit is processed as follows: the register's top bit is XORed with the data bit, the register shifts left with a 0 entering, and it is XORed with the polynomial (5'h05 or 16'h8005) when that XOR was 1.
- R9: Each packet ends with two SE0 symbols and then one J. The line then idles at J.
- R10: The line changes only in the clock cycle that follows a bit-enable strobe.
- R11: `busy_o` rises in the cycle after a request is accepted. It stays high until the edge that drives the final J of EOP. At that edge `busy_o` falls and `done_o` pulses for one cycle.
- R12: A request is accepted only when idle (`req_ready_o`=1 exactly while not busy). A request with a kind code above 8 is dropped: the block stays idle and the line stays at J.
- R13: Handshake kinds (codes 6 to 8) send only SYNC, PID and EOP.
- R14: `byte_ready_o` is raised only during a data-kind packet, while the one-byte holding register is empty and bytes remain to be fetched. Exactly `req_len_i` bytes are taken, and non-data kinds take none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe; one line symbol per strobe |
| req_valid_i | input | 1 | Packet request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_kind_i | input | 4 | Packet kind code (see R3) |
| req_addr_i | input | 7 | Token device address |
| req_endp_i | input | 4 | Token endpoint number |
| req_frame_i | input | 11 | SOF frame number |
| req_len_i | input | LEN_W (7) | Data payload length in bytes, up to MAX_BYTES |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_ready_o | output | 1 | Payload byte taken when high together with valid |
| byte_data_i | input | 8 | Payload byte |
| line_dp_o | output | 1 | Data wire: 1 = J, 0 = K when not SE0 |
| line_se0_o | output | 1 | SE0 flag |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse at packet completion |

## Verification
The properties assume three things about the inputs. First, the payload stream refills the holding register before the shifter needs the next byte, so an underrun is treated as an error. Second, `req_len_i` never exceeds MAX_BYTES. Third, `bit_en_i` is a single-cycle pulse.

The stimulus keeps `byte_valid_i` high whenever bytes remain, with the next payload byte already presented. It spaces strobes four clocks apart, which leaves many cycles per byte for the refill. It also uses lengths of 0 to 4 bytes.

Each packet's symbol stream is compared against a model built from the coding rules above. That model computes SYNC, PID, fields, stuffing and CRC bit by bit.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [3:0] {
    KIND_OUT   = 4'd0,
    KIND_IN    = 4'd1,
    KIND_SETUP = 4'd2,
    KIND_SOF   = 4'd3,
    KIND_DATA0 = 4'd4,
    KIND_DATA1 = 4'd5,
    KIND_ACK   = 4'd6,
    KIND_NAK   = 4'd7,
    KIND_STALL = 4'd8
  } pkt_kind_e;

  typedef enum logic [1:0] {
    SYM_BIT = 2'd0,
    SYM_J   = 2'd1,
    SYM_K   = 2'd2,
    SYM_SE0 = 2'd3
  } sym_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SYNC = 3'd1,
    ST_PID  = 3'd2,
    ST_FLD  = 3'd3,
    ST_DATA = 3'd4,
    ST_CRC  = 3'd5,
    ST_SE0  = 3'd6,
    ST_EOPJ = 3'd7
  } tx_st_e;

  localparam logic [4:0]  CRC5_POLY  = 5'h05;
  localparam logic [15:0] CRC16_POLY = 16'h8005;
  localparam int unsigned STUFF_RUN  = 6;
  localparam int unsigned SYNC_LEN   = 8;
  localparam int unsigned FLD_LEN    = 11;

  function automatic logic kind_ok(logic [3:0] k);
    return k <= KIND_STALL;
  endfunction

  function automatic logic kind_tok(logic [3:0] k);
    return k <= KIND_SOF;
  endfunction

  function automatic logic kind_data(logic [3:0] k);
    return (k == KIND_DATA0) || (k == KIND_DATA1);
  endfunction

  function automatic logic [7:0] pid_of(logic [3:0] k);
    logic [7:0] p;
    case (k)
      KIND_OUT:   p = 8'hE1;
      KIND_IN:    p = 8'h69;
      KIND_SETUP: p = 8'h2D;
      KIND_SOF:   p = 8'hA5;
      KIND_DATA0: p = 8'hC3;
      KIND_DATA1: p = 8'h4B;
      KIND_ACK:   p = 8'hD2;
      KIND_NAK:   p = 8'h5A;
      default:    p = 8'h1E;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/usb_tx_crc.sv
module usb_tx_crc #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         seed_i,
  input  logic         feed_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = crc_q[W-1] ^ bit_i;
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (seed_i) crc_q <= '1;
    else if (feed_i) crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/usb_tx_line.sv
module usb_tx_line
  import usb_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic active_i,
  input  sym_e sym_i,
  input  logic bit_i,
  output logic adv_o,
  output logic dp_o,
  output logic se0_o
);
  localparam int unsigned OW = $clog2(STUFF_RUN + 1);

  logic          lvl_q, se0_q;
  logic [OW-1:0] ones_q;
  logic          stuff_w, step_w;

  assign stuff_w = (ones_q == OW'(STUFF_RUN));
  assign step_w  = bit_en_i & active_i;
  assign adv_o   = step_w & ~stuff_w;
  assign dp_o    = lvl_q;
  assign se0_o   = se0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      se0_q  <= 1'b0;
      ones_q <= '0;
    end else if (step_w) begin
      if (stuff_w) begin
        // inserted level: pure toggle, no data consumed
        lvl_q  <= ~lvl_q;
        se0_q  <= 1'b0;
        ones_q <= '0;
      end else begin
        unique case (sym_i)
          SYM_BIT: begin
            se0_q <= 1'b0;
            if (bit_i) ones_q <= ones_q + 1'b1;
            else begin
              lvl_q  <= ~lvl_q;
              ones_q <= '0;
            end
          end
          SYM_J: begin
            lvl_q  <= 1'b1;
            se0_q  <= 1'b0;
            ones_q <= '0;
          end
          SYM_K: begin
            lvl_q  <= 1'b0;
            se0_q  <= 1'b0;
            ones_q <= '0;
          end
          SYM_SE0: begin
            se0_q  <= 1'b1;
            ones_q <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/usb_tx_ctrl.sv
module usb_tx_ctrl
  import usb_tx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 64,
  parameter int unsigned LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [3:0]       req_kind_i,
  input  logic [6:0]       req_addr_i,
  input  logic [3:0]       req_endp_i,
  input  logic [10:0]      req_frame_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic [7:0]       byte_data_i,
  input  logic [4:0]       crc5_i,
  input  logic [15:0]      crc16_i,
  output logic             active_o,
  output sym_e             sym_o,
  output logic             bit_o,
  output logic             crc_seed_o,
  output logic             crc5_feed_o,
  output logic             crc16_feed_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             byte_load_o,
  output logic             hold_full_o
);
  tx_st_e             st_q, nxt_st;
  logic [3:0]         cnt_q, last_idx;
  logic [3:0]         kind_q;
  logic [FLD_LEN-1:0] fld_q;
  logic [LEN_W-1:0]   len_q, sent_q, fetch_q;
  logic [7:0]         hold_q, sh_q;
  logic               hold_vld_q, done_q;
  logic               accept, last_w, fire, is_tok, is_data;
  logic [7:0]         pid_w;

  assign is_tok  = kind_tok(kind_q);
  assign is_data = kind_data(kind_q);
  assign pid_w   = pid_of(kind_q);

  assign active_o    = (st_q != ST_IDLE);
  assign busy_o      = active_o;
  assign req_ready_o = ~active_o;
  assign accept      = req_valid_i & req_ready_o & kind_ok(req_kind_i);
  assign done_o      = done_q;

  assign byte_ready_o = active_o & is_data & ~hold_vld_q & (fetch_q != len_q);
  assign fire         = byte_valid_i & byte_ready_o;
  assign hold_full_o  = hold_vld_q;

  always_comb begin
    sym_o    = SYM_J;
    bit_o    = 1'b1;
    last_idx = 4'd0;
    unique case (st_q)
      ST_SYNC: begin
        sym_o    = (cnt_q == 4'd7 || !cnt_q[0]) ? SYM_K : SYM_J;
        last_idx = 4'(SYNC_LEN - 1);
      end
      ST_PID: begin
        sym_o    = SYM_BIT;
        bit_o    = pid_w[cnt_q[2:0]];
        last_idx = 4'd7;
      end
      ST_FLD: begin
        sym_o    = SYM_BIT;
        bit_o    = fld_q[cnt_q];
        last_idx = 4'(FLD_LEN - 1);
      end
      ST_DATA: begin
        sym_o    = SYM_BIT;
        bit_o    = sh_q[cnt_q[2:0]];
        last_idx = 4'd7;
      end
      ST_CRC: begin
        sym_o    = SYM_BIT;
        // complemented remainder, MSB first
        bit_o    = is_data ? ~crc16_i[4'd15 - cnt_q] : ~crc5_i[3'd4 - cnt_q[2:0]];
        last_idx = is_data ? 4'd15 : 4'd4;
      end
      ST_SE0: begin
        sym_o    = SYM_SE0;
        last_idx = 4'd1;
      end
      ST_EOPJ: sym_o = SYM_J;
      default: ;
    endcase
  end

  assign last_w = (cnt_q == last_idx);

  always_comb begin
    nxt_st = st_q;
    unique case (st_q)
      ST_SYNC: nxt_st = ST_PID;
      ST_PID: begin
        if (is_tok)       nxt_st = ST_FLD;
        else if (is_data) nxt_st = (len_q == '0) ? ST_CRC : ST_DATA;
        else              nxt_st = ST_SE0;
      end
      ST_FLD:  nxt_st = ST_CRC;
      ST_DATA: nxt_st = (sent_q == len_q) ? ST_CRC : ST_DATA;
      ST_CRC:  nxt_st = ST_SE0;
      ST_SE0:  nxt_st = ST_EOPJ;
      ST_EOPJ: nxt_st = ST_IDLE;
      default: nxt_st = ST_IDLE;
    endcase
  end

  assign byte_load_o  = adv_i & last_w &
                        (((st_q == ST_PID) & is_data & (len_q != '0)) |
                         ((st_q == ST_DATA) & (sent_q != len_q)));
  assign crc_seed_o   = adv_i & last_w & (st_q == ST_PID);
  assign crc5_feed_o  = adv_i & (st_q == ST_FLD);
  assign crc16_feed_o = adv_i & (st_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      kind_q     <= '0;
      fld_q      <= '0;
      len_q      <= '0;
      sent_q     <= '0;
      fetch_q    <= '0;
      hold_q     <= '0;
      sh_q       <= '0;
      hold_vld_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= adv_i & last_w & (st_q == ST_EOPJ);
      if (accept) begin
        st_q       <= ST_SYNC;
        cnt_q      <= '0;
        kind_q     <= req_kind_i;
        fld_q      <= (req_kind_i == KIND_SOF) ? req_frame_i : {req_endp_i, req_addr_i};
        len_q      <= req_len_i;
        sent_q     <= '0;
        fetch_q    <= '0;
        hold_vld_q <= 1'b0;
      end else if (adv_i) begin
        if (last_w) begin
          cnt_q <= '0;
          st_q  <= nxt_st;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (byte_load_o) begin
        sh_q       <= hold_q;
        hold_vld_q <= 1'b0;
        sent_q     <= sent_q + 1'b1;
      end
      if (fire) begin
        hold_q     <= byte_data_i;
        hold_vld_q <= 1'b1;
        fetch_q    <= fetch_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_fs_pkt_tx.sv
module usb_fs_pkt_tx
  import usb_tx_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 64,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [3:0]       req_kind_i,
  input  logic [6:0]       req_addr_i,
  input  logic [3:0]       req_endp_i,
  input  logic [10:0]      req_frame_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic [7:0]       byte_data_i,
  output logic             line_dp_o,
  output logic             line_se0_o,
  output logic             busy_o,
  output logic             done_o
);
  logic        adv, active, bit_w, seed, feed5, feed16;
  logic        byte_load, hold_full;
  sym_e        sym_w;
  logic [4:0]  crc5;
  logic [15:0] crc16;

  usb_tx_ctrl #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_kind_i   (req_kind_i),
    .req_addr_i   (req_addr_i),
    .req_endp_i   (req_endp_i),
    .req_frame_i  (req_frame_i),
    .req_len_i    (req_len_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .byte_data_i  (byte_data_i),
    .crc5_i       (crc5),
    .crc16_i      (crc16),
    .active_o     (active),
    .sym_o        (sym_w),
    .bit_o        (bit_w),
    .crc_seed_o   (seed),
    .crc5_feed_o  (feed5),
    .crc16_feed_o (feed16),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .byte_load_o  (byte_load),
    .hold_full_o  (hold_full)
  );

  usb_tx_line u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .active_i (active),
    .sym_i    (sym_w),
    .bit_i    (bit_w),
    .adv_o    (adv),
    .dp_o     (line_dp_o),
    .se0_o    (line_se0_o)
  );

  usb_tx_crc #(.W(5), .POLY(CRC5_POLY)) u_crc5 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (seed),
    .feed_i (feed5),
    .bit_i  (bit_w),
    .crc_o  (crc5)
  );

  usb_tx_crc #(.W(16), .POLY(CRC16_POLY)) u_crc16 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (seed),
    .feed_i (feed16),
    .bit_i  (bit_w),
    .crc_o  (crc16)
  );
endmodule

// File: rtl/usb_fs_pkt_tx_chk.sv
module usb_fs_pkt_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic line_dp_o,
  input logic line_se0_o,
  input logic busy_o,
  input logic done_o,
  input logic req_ready_o,
  input logic byte_ready_o,
  input logic byte_load,
  input logic hold_full
);
  logic       upd_q, last_dp_q;
  logic [3:0] run_q;

  // length of the current run of equal non-SE0 levels within a packet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q     <= 1'b0;
      last_dp_q <= 1'b1;
      run_q     <= '0;
    end else begin
      upd_q <= bit_en_i;
      if (upd_q) last_dp_q <= line_dp_o;
      if (!busy_o) run_q <= '0;
      else if (upd_q) begin
        if (line_se0_o || line_dp_o != last_dp_q) run_q <= 4'd1;
        else if (run_q != 4'hF) run_q <= run_q + 1'b1;
      end
    end
  end

  AST_STUFF_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 4'd8) else $error("level run too long"); // R5
  AST_IDLE_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (line_dp_o && !line_se0_o)); // R9
  AST_SE0_TO_J: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_se0_o) |-> line_dp_o); // R9
  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_en_i) |-> ($stable(line_dp_o) && $stable(line_se0_o))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R11
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o); // R12
  AST_NO_BYTE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !byte_ready_o); // R14
  AST_NO_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_load |-> hold_full); // R14
endmodule

bind usb_fs_pkt_tx usb_fs_pkt_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_en_i     (bit_en_i),
  .line_dp_o    (line_dp_o),
  .line_se0_o   (line_se0_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .req_ready_o  (req_ready_o),
  .byte_ready_o (byte_ready_o),
  .byte_load    (byte_load),
  .hold_full    (hold_full)
);

// File: tb/sim_usb_fs_pkt_tx.sv
`timescale 1ns/1ps
module sim_usb_fs_pkt_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [3:0]  req_kind_i = '0;
  logic [6:0]  req_addr_i = '0;
  logic [3:0]  req_endp_i = '0;
  logic [10:0] req_frame_i = '0;
  logic [6:0]  req_len_i = '0;
  logic        byte_valid_i = 1'b0;
  logic        byte_ready_o;
  logic [7:0]  byte_data_i = '0;
  logic        line_dp_o, line_se0_o, busy_o, done_o;

  int vec = 0;
  int bad = 0;
  int idx = 0;
  int offer = 0;
  logic [7:0] payload [0:15];
  int exp_sym [0:2047];
  int got_sym [0:2047];
  int exp_n;
  logic m_lvl;
  int m_ones;
  logic [4:0]  m_c5;
  logic [15:0] m_c16;

  always #2.5 clk_i = ~clk_i;

  usb_fs_pkt_tx u0 (.*);

  initial begin
    #900000;
    bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_pid(input logic [3:0] k);
    case (k)
      4'd0: return 8'hE1;
      4'd1: return 8'h69;
      4'd2: return 8'h2D;
      4'd3: return 8'hA5;
      4'd4: return 8'hC3;
      4'd5: return 8'h4B;
      4'd6: return 8'hD2;
      4'd7: return 8'h5A;
      default: return 8'h1E;
    endcase
  endfunction

  function automatic int cur_sym();
    return line_se0_o ? 2 : int'(line_dp_o);
  endfunction

  task automatic put(input int s);
    exp_sym[exp_n] = s;
    exp_n++;
  endtask

  // NRZI plus stuffing model (symbols: 0=K, 1=J, 2=SE0)
  task automatic put_bit(input logic b);
    if (!b) begin
      m_lvl  = ~m_lvl;
      m_ones = 0;
    end else m_ones++;
    put(int'(m_lvl));
    if (m_ones == 6) begin
      m_lvl  = ~m_lvl;
      m_ones = 0;
      put(int'(m_lvl));
    end
  endtask

  task automatic crc5_bit(input logic b);
    logic fb;
    fb = m_c5[4] ^ b;
    m_c5 = {m_c5[3:0], 1'b0};
    if (fb) m_c5 = m_c5 ^ 5'h05;
  endtask

  task automatic crc16_bit(input logic b);
    logic fb;
    fb = m_c16[15] ^ b;
    m_c16 = {m_c16[14:0], 1'b0};
    if (fb) m_c16 = m_c16 ^ 16'h8005;
  endtask

  task automatic build(input logic [3:0] k, input logic [6:0] a, input logic [3:0] e,
                       input logic [10:0] f, input int len);
    logic [7:0]  p;
    logic [10:0] fld;
    exp_n = 0;
    put(0); put(1); put(0); put(1); put(0); put(1); put(0); put(0);
    m_lvl = 1'b0; m_ones = 0;
    p = exp_pid(k);
    for (int i = 0; i < 8; i++) put_bit(p[i]);
    m_c5 = '1; m_c16 = '1;
    if (k <= 4'd3) begin
      fld = (k == 4'd3) ? f : {e, a};
      for (int i = 0; i < 11; i++) begin
        put_bit(fld[i]);
        crc5_bit(fld[i]);
      end
      for (int i = 0; i < 5; i++) put_bit(~m_c5[4-i]);
    end else if (k == 4'd4 || k == 4'd5) begin
      for (int j = 0; j < len; j++)
        for (int i = 0; i < 8; i++) begin
          put_bit(payload[j][i]);
          crc16_bit(payload[j][i]);
        end
      for (int i = 0; i < 16; i++) put_bit(~m_c16[15-i]);
    end
    put(2); put(2); put(1);
  endtask

  task automatic clk_step();
    bit fire;
    fire = byte_valid_i & byte_ready_o;
    @(posedge clk_i);
    @(negedge clk_i);
    if (fire) idx++;
    byte_valid_i = (idx < offer);
    byte_data_i  = payload[idx & 15];
  endtask

  task automatic bit_time();
    bit_en_i = 1'b0;
    repeat (3) clk_step();
    bit_en_i = 1'b1;
    clk_step();
    bit_en_i = 1'b0;
  endtask

  task automatic cmp_range(input int lo, input int hi, input string tag);
    int bad_at;
    bad_at = -1;
    for (int i = lo; i <= hi; i++)
      if (bad_at < 0 && got_sym[i] != exp_sym[i]) bad_at = i;
    if (bad_at < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s symbol %0d", tag, bad_at), got_sym[bad_at], exp_sym[bad_at]);
  endtask

  task automatic run_pkt(input logic [3:0] k, input logic [6:0] a, input logic [3:0] e,
                         input logic [10:0] f, input int len, input int off, input string tag);
    int busy_bad, taken;
    build(k, a, e, f, len);
    idx = 0; offer = off;
    byte_valid_i = (off > 0);
    byte_data_i  = payload[0];
    req_kind_i = k; req_addr_i = a; req_endp_i = e; req_frame_i = f; req_len_i = 7'(len);
    req_valid_i = 1'b1;
    clk_step();
    req_valid_i = 1'b0;
    check(busy_o == 1'b1, {tag, " R11 busy after accept"}, int'(busy_o), 1);
    check(req_ready_o == 1'b0, {tag, " R12 ready low while busy"}, int'(req_ready_o), 0);
    busy_bad = 0;
    for (int i = 0; i < exp_n; i++) begin
      bit_time();
      got_sym[i] = cur_sym();
      if (i < exp_n - 1 && (!busy_o || done_o)) busy_bad++;
    end
    cmp_range(0, 7, {tag, " R2 sync"});
    cmp_range(8, 15, {tag, " R3 R4 pid"});
    if (exp_n - 4 >= 16) cmp_range(16, exp_n - 4, {tag, " R5 body"});
    cmp_range(exp_n - 3, exp_n - 1, {tag, " R9 eop"});
    check(busy_bad == 0, {tag, " R11 busy held"}, busy_bad, 0);
    check(!busy_o && done_o, {tag, " R11 done at final J"}, int'({busy_o, done_o}), 1);
    bit_time();
    check(!done_o && line_dp_o && !line_se0_o, {tag, " R9 idle J after"},
          int'({done_o, line_dp_o, line_se0_o}), 2);
    taken = (k == 4'd4 || k == 4'd5) ? len : 0;
    check(idx == taken, {tag, " R14 bytes taken"}, idx, taken);
    offer = 0; byte_valid_i = 1'b0;
  endtask

  task automatic test_reset();
    check(line_dp_o && !line_se0_o, "R1 line J", int'({line_dp_o, line_se0_o}), 2);
    check(!busy_o && !done_o, "R1 busy/done low", int'({busy_o, done_o}), 0);
    check(req_ready_o && !byte_ready_o, "R1 ready state", int'({req_ready_o, byte_ready_o}), 2);
  endtask

  task automatic test_tokens();
    run_pkt(4'd0, 7'h3A, 4'h5, 11'h0, 0, 2, "R6 OUT");
    run_pkt(4'd1, 7'h7F, 4'hF, 11'h0, 0, 0, "R6 IN stuffed");
    run_pkt(4'd2, 7'h00, 4'h0, 11'h0, 0, 0, "R6 SETUP");
    run_pkt(4'd3, 7'h00, 4'h0, 11'h7FF, 0, 0, "R6 SOF ones");
    run_pkt(4'd3, 7'h00, 4'h0, 11'h2A5, 0, 0, "R6 SOF mixed");
  endtask

  task automatic test_data();
    payload[0] = 8'h01; payload[1] = 8'h23; payload[2] = 8'h45; payload[3] = 8'hA7;
    run_pkt(4'd4, 7'h0, 4'h0, 11'h0, 4, 4, "R7 R8 DATA0");
    payload[0] = 8'hFF; payload[1] = 8'hFF; payload[2] = 8'hFF;
    run_pkt(4'd5, 7'h0, 4'h0, 11'h0, 3, 3, "R5 R7 DATA1 ones");
    run_pkt(4'd5, 7'h0, 4'h0, 11'h0, 0, 2, "R7 zero length");
  endtask

  task automatic test_handshake();
    run_pkt(4'd6, 7'h0, 4'h0, 11'h0, 0, 2, "R13 ACK");
    run_pkt(4'd7, 7'h0, 4'h0, 11'h0, 0, 0, "R13 NAK");
    run_pkt(4'd8, 7'h0, 4'h0, 11'h0, 0, 0, "R13 STALL");
  endtask

  task automatic test_hold();
    int s0, n;
    req_kind_i = 4'd6; req_valid_i = 1'b1;
    clk_step();
    req_valid_i = 1'b0;
    bit_time();
    s0 = cur_sym();
    check(s0 == 0, "R10 first symbol K", s0, 0);
    repeat (10) clk_step();
    check(cur_sym() == s0, "R10 no change without strobe", cur_sym(), s0);
    n = 0;
    while (busy_o && n < 40) begin
      bit_time();
      n++;
    end
    check(!busy_o, "R10 packet completes", int'(busy_o), 0);
  endtask

  task automatic test_bad_kind();
    int moved;
    req_kind_i = 4'd12; req_valid_i = 1'b1;
    clk_step();
    req_valid_i = 1'b0;
    check(!busy_o && req_ready_o, "R12 bad kind dropped", int'({busy_o, req_ready_o}), 1);
    moved = 0;
    for (int i = 0; i < 6; i++) begin
      bit_time();
      if (cur_sym() != 1 || busy_o) moved++;
    end
    check(moved == 0, "R12 line stays J", moved, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_tokens();
    test_data();
    test_handshake();
    test_hold();
    test_bad_kind();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule